// File: doc/BRIEF.md
# Bundle Template Decoder and Dispatcher

This block sits between bundle fetch and the execution units of a statically scheduled wide-issue core. Each cycle it looks at up to two 128-bit bundles. A bundle holds a 5-bit template code and three 41-bit instruction slots. For each bundle the block decodes the template to learn which unit class each slot needs and where stop markers lie. It then hands slots, in program order, to a fixed pool of execution-unit ports.

Issue for the cycle ends at a stop marker or at the first slot that finds no free unit of a usable class. The block remembers which slot to resume from. The producer learns how many bundles were fully dispatched from a count. It shifts its window by that count before the next clock edge, so the count serves as the input's ready indication.

All dispatch outputs are combinational in the cycle the bundles are presented. The only state is the resume slot inside the oldest bundle.

Top module: `bundle_dispatch`

## Requirements
- R1: A bundle carries its template code in bits [4:0], slot 0 in bits [45:5], slot 1 in [86:46] and slot 2 in [127:87]. Template bits [4:2] select the slot layout and bits [1:0] the stop: 0 means none, and k (1 to 3) means a stop after slot k-1.
- R2: Layout codes 0..6 give the slot classes (slot 0, 1, 2) as MEM INT INT, MEM EXT-pair, MEM MEM INT, MEM FP INT, MEM INT BR, BR BR BR and MEM FP BR. The unit ports are indexed INT 0-1, MEM 2-3, FP 4-5, BR 6-8 and EXT 9, and within a class the lowest free index is used first.
- R3: A slot in an INT or MEM position whose bit 40 is set is an ALU operation. When its own class is full it goes to a free unit of the other class; with bit 40 clear it never changes class.
- R4: Slots are placed strictly in order across the two bundles. The first slot that cannot be placed ends the cycle, and the next cycle restarts at that slot.
- R5: A stop after a slot ends issue for the cycle once that slot is placed. The following slot, whether later in the same bundle or in the next bundle, issues no earlier than the next cycle.
- R6: The extended-immediate pair in slots 1 and 2 is dispatched as one operation to the EXT port. `unit_ins[9]` carries slot 2 and `ext_lo` carries slot 1; with no free EXT port, issue ends at slot 1.
- R7: Layout code 7, or layout 1 combined with stop code 2, is illegal. In that case `bad_tmpl` rises, nothing of that bundle is dispatched, the bundle counts as consumed and issue ends for the cycle.
- R8: `bnd_used` equals the number of bundles, from the oldest, whose remaining slots were all dispatched (or which were dropped as illegal) this cycle. The second lane is examined only after the first lane's bundle is finished without a stop on its last slot.
- R9: With lane 0 invalid, no unit port is valid, `bnd_used` is 0, `bad_tmpl` is low and the resume slot is kept.
- R10: Reset sets the resume slot to 0, so the next bundle presented is dispatched from slot 0.
- R11: At most six unit ports are valid in a cycle. When lane 0 holds a legal bundle, at least one port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 2 | Lane valid bits; lane 1 only with lane 0 |
| in_bnd0 | input | 128 | Oldest bundle in the window |
| in_bnd1 | input | 128 | Next bundle in the window |
| bnd_used | output | 2 | Bundles consumed this cycle |
| bad_tmpl | output | 1 | Illegal template seen this cycle |
| unit_vld | output | 10 | Per-unit-port dispatch valid |
| unit_ins | output | 10x41 | Per-unit-port instruction word |
| ext_lo | output | 41 | Low half of the extended-immediate pair |

## Verification
Every dispatch result, the consumed count and the illegal flag are due in the same cycle the window is presented. The resume slot takes effect only after the following rising edge. The bench therefore drives the window on the falling edge and compares all outputs 1 ns later, well before the next rising edge. It then waits for that edge and removes the consumed bundles from its queue, so the reference model and the design always see the same window and the same resume point.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;
   localparam int SLOT_W = 41;
   localparam int TMPL_W = 5;
   localparam int BND_W  = 128;

   localparam int CL_INT = 0;
   localparam int CL_MEM = 1;
   localparam int CL_FP  = 2;
   localparam int CL_BR  = 3;
   localparam int CL_EXT = 4;
   localparam int NCLS   = 5;

   typedef enum logic [2:0] {SK_M, SK_I, SK_F, SK_B, SK_L, SK_X} slot_kind_e;

   typedef struct packed {
      slot_kind_e [2:0] kind;
      logic [2:0]       stop;
      logic             bad;
   } tmpl_info_t;

   function automatic tmpl_info_t tmpl_decode(input logic [TMPL_W-1:0] t);
      tmpl_info_t r;
      r.bad  = 1'b0;
      r.stop = 3'b000;
      r.kind[0] = SK_M;
      r.kind[1] = SK_I;
      r.kind[2] = SK_I;
      case (t[4:2])
         3'd0: ;
         3'd1: begin r.kind[1] = SK_L; r.kind[2] = SK_X; end
         3'd2: r.kind[1] = SK_M;
         3'd3: r.kind[1] = SK_F;
         3'd4: r.kind[2] = SK_B;
         3'd5: begin r.kind[0] = SK_B; r.kind[1] = SK_B; r.kind[2] = SK_B; end
         3'd6: begin r.kind[1] = SK_F; r.kind[2] = SK_B; end
         default: r.bad = 1'b1;
      endcase
      case (t[1:0])
         2'd1: r.stop = 3'b001;
         2'd2: r.stop = 3'b010;
         2'd3: r.stop = 3'b100;
         default: r.stop = 3'b000;
      endcase
      if (t[4:2] == 3'd1 && t[1:0] == 2'd2) r.bad = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/bdisp_tmpl_dec.sv
module bdisp_tmpl_dec
   import bdisp_pkg::*;
(
   input  logic [TMPL_W-1:0] tmpl,
   output tmpl_info_t        info
);
   assign info = tmpl_decode(tmpl);
endmodule

// File: rtl/bdisp_walk.sv
module bdisp_walk
   import bdisp_pkg::*;
#(
   parameter int INT_N = 2,
   parameter int MEM_N = 2,
   parameter int FP_N  = 2,
   parameter int BR_N  = 3,
   parameter int NU    = INT_N + MEM_N + FP_N + BR_N + 1
)(
   input  logic [1:0]                   lane_vld,
   input  logic [1:0][BND_W-1:0]        bnd,
   input  tmpl_info_t [1:0]             info,
   input  logic [1:0]                   off,
   output logic [NU-1:0]                u_vld,
   output logic [NU-1:0][SLOT_W-1:0]    u_ins,
   output logic [SLOT_W-1:0]            x_lo,
   output logic [1:0]                   used,
   output logic                         ill,
   output logic [1:0]                   nxt_off
);
   localparam int CAP  [NCLS] = '{INT_N, MEM_N, FP_N, BR_N, 1};
   localparam int BASE [NCLS] = '{0, INT_N, INT_N + MEM_N, INT_N + MEM_N + FP_N,
                                  INT_N + MEM_N + FP_N + BR_N};

   always_comb begin
      int              cnt [NCLS];
      int              pos;
      int              prim;
      int              alt;
      int              cls;
      int              idx;
      logic            live;
      logic            placed;
      logic [SLOT_W-1:0] word;
      slot_kind_e      k;

      u_vld   = '0;
      u_ins   = '0;
      x_lo    = '0;
      used    = 2'd0;
      ill     = 1'b0;
      nxt_off = off;
      live    = 1'b1;
      pos     = 0;
      prim    = -1;
      alt     = -1;
      cls     = -1;
      idx     = 0;
      placed  = 1'b0;
      word    = '0;
      k       = SK_X;
      for (int c = 0; c < NCLS; c++) cnt[c] = 0;

      for (int l = 0; l < 2; l++) begin
         if (live && lane_vld[l]) begin
            if (info[l].bad) begin
               ill     = 1'b1;
               used    = used + 2'd1;
               nxt_off = 2'd0;
               live    = 1'b0;
            end else begin
               pos = (l == 0) ? int'(off) : 0;
               for (int s = 0; s < 3; s++) begin
                  if (live && s >= pos) begin
                     word   = bnd[l][TMPL_W + SLOT_W*s +: SLOT_W];
                     k      = info[l].kind[s];
                     placed = 1'b0;
                     alt    = -1;
                     cls    = -1;
                     case (k)
                        SK_I: begin prim = CL_INT; if (word[SLOT_W-1]) alt = CL_MEM; end
                        SK_M: begin prim = CL_MEM; if (word[SLOT_W-1]) alt = CL_INT; end
                        SK_F: prim = CL_FP;
                        SK_B: prim = CL_BR;
                        SK_L: prim = CL_EXT;
                        default: prim = -1;
                     endcase
                     if (prim < 0) begin
                        placed = 1'b1;
                     end else if (cnt[prim] < CAP[prim]) begin
                        cls = prim;
                     end else if (alt >= 0 && cnt[alt] < CAP[alt]) begin
                        cls = alt;
                     end
                     if (cls >= 0) begin
                        idx        = BASE[cls] + cnt[cls];
                        u_vld[idx] = 1'b1;
                        if (k == SK_L) begin
                           u_ins[idx] = bnd[l][TMPL_W + SLOT_W*2 +: SLOT_W];
                           x_lo       = word;
                        end else begin
                           u_ins[idx] = word;
                        end
                        cnt[cls] = cnt[cls] + 1;
                        placed   = 1'b1;
                     end
                     if (placed) begin
                        pos = s + 1;
                        if (info[l].stop[s]) live = 1'b0;
                     end else begin
                        live = 1'b0;
                     end
                  end
               end
               if (pos == 3) begin
                  used    = used + 2'd1;
                  nxt_off = 2'd0;
               end else begin
                  nxt_off = pos[1:0];
               end
            end
         end
      end
   end
endmodule

// File: rtl/bdisp_resume.sv
module bdisp_resume (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] off_d,
   output logic [1:0] off_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) off_q <= 2'd0;
      else        off_q <= off_d;
   end
endmodule

// File: rtl/bundle_dispatch.sv
module bundle_dispatch
   import bdisp_pkg::*;
#(
   parameter int INT_N = 2,
   parameter int MEM_N = 2,
   parameter int FP_N  = 2,
   parameter int BR_N  = 3
)(
   input  logic                                            clk,
   input  logic                                            rst_n,
   input  logic [1:0]                                      in_vld,
   input  logic [BND_W-1:0]                                in_bnd0,
   input  logic [BND_W-1:0]                                in_bnd1,
   output logic [1:0]                                      bnd_used,
   output logic                                            bad_tmpl,
   output logic [INT_N+MEM_N+FP_N+BR_N:0]                  unit_vld,
   output logic [INT_N+MEM_N+FP_N+BR_N:0][SLOT_W-1:0]      unit_ins,
   output logic [SLOT_W-1:0]                               ext_lo
);
   localparam int NU = INT_N + MEM_N + FP_N + BR_N + 1;

   if (INT_N < 1 || MEM_N < 1 || FP_N < 1 || BR_N < 1) begin : g_bad_pool
      $error("every unit class needs at least one port");
   end
   if (TMPL_W + 3*SLOT_W != BND_W) begin : g_bad_fmt
      $error("bundle fields do not fill the bundle width");
   end

   logic [1:0][BND_W-1:0] lane_bnd;
   tmpl_info_t [1:0]      info;
   logic [1:0]            off_q;
   logic [1:0]            off_d;

   assign lane_bnd[0] = in_bnd0;
   assign lane_bnd[1] = in_bnd1;

   for (genvar g = 0; g < 2; g++) begin : g_dec
      bdisp_tmpl_dec u_dec (
         .tmpl (lane_bnd[g][TMPL_W-1:0]),
         .info (info[g])
      );
   end

   bdisp_walk #(
      .INT_N (INT_N),
      .MEM_N (MEM_N),
      .FP_N  (FP_N),
      .BR_N  (BR_N),
      .NU    (NU)
   ) u_walk (
      .lane_vld (in_vld),
      .bnd      (lane_bnd),
      .info     (info),
      .off      (off_q),
      .u_vld    (unit_vld),
      .u_ins    (unit_ins),
      .x_lo     (ext_lo),
      .used     (bnd_used),
      .ill      (bad_tmpl),
      .nxt_off  (off_d)
   );

   bdisp_resume u_res (
      .clk   (clk),
      .rst_n (rst_n),
      .off_d (off_d),
      .off_q (off_q)
   );
endmodule

// File: rtl/bdisp_chk.sv
module bdisp_chk #(
   parameter int NU = 10
)(
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    in_vld,
   input logic [1:0]    bnd_used,
   input logic          bad_tmpl,
   input logic [NU-1:0] unit_vld
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld[0] |-> (unit_vld == '0 && bnd_used == 2'd0 && !bad_tmpl)); // R9
   AST_PAIR_NEEDS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_used == 2'd2) |-> (in_vld == 2'b11)); // R8
   AST_ISSUE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(unit_vld) <= 6); // R11
   AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld[0] && !bad_tmpl) |-> (unit_vld != '0)); // R11
   AST_BAD_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
      bad_tmpl |-> (bnd_used != 2'd0)); // R7
   AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_used != 2'd0) |-> in_vld[0]); // R8
endmodule

bind bundle_dispatch bdisp_chk #(.NU(NU)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .bnd_used (bnd_used),
   .bad_tmpl (bad_tmpl),
   .unit_vld (unit_vld)
);

// File: tb/bundle_dispatch_tb.sv
module bundle_dispatch_tb;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        in_vld = 2'b00;
   logic [127:0]      in_bnd0 = '0;
   logic [127:0]      in_bnd1 = '0;
   logic [1:0]        bnd_used;
   logic              bad_tmpl;
   logic [9:0]        unit_vld;
   logic [9:0][40:0]  unit_ins;
   logic [40:0]       ext_lo;

   bundle_dispatch u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bnd0(in_bnd0), .in_bnd1(in_bnd1),
      .bnd_used(bnd_used), .bad_tmpl(bad_tmpl), .unit_vld(unit_vld),
      .unit_ins(unit_ins), .ext_lo(ext_lo)
   );

   always #2 clk = ~clk;

   int          n_chk = 0;
   int          n_bad = 0;
   bit [127:0]  q[$];
   int          m_off = 0;
   string       LAY [7] = '{"MII", "MLX", "MMI", "MFI", "MIB", "BBB", "MFB"};
   int          BASE_M [5] = '{0, 2, 4, 6, 9};
   int          CAP_M  [5] = '{2, 2, 2, 3, 1};

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int cls_of(byte c);
      case (c)
         "I": return 0;
         "M": return 1;
         "F": return 2;
         "B": return 3;
         "L": return 4;
         default: return -1;
      endcase
   endfunction

   function automatic bit [127:0] mk(int lay, int st, bit [2:0] alu, int id);
      bit [127:0] b;
      b[4:0] = {3'(lay), 2'(st)};
      for (int s = 0; s < 3; s++)
         b[5 + 41*s +: 41] = {alu[s], 8'(id), 8'(s + 1), 24'(id * 7919 + s * 131)};
      return b;
   endfunction

   task automatic model(input bit [127:0] b0, input bit [127:0] b1, input bit v0, input bit v1,
                        input int off, output bit [9:0] ev, output bit [9:0][40:0] ei,
                        output bit [40:0] elo, output int eu, output bit eill, output int noff);
      int room [5];
      bit go;
      bit [127:0] b;
      int at, lay, st, c, alt, u;
      byte k;
      bit [40:0] w;
      ev = '0; ei = '0; elo = '0; eu = 0; eill = 0; noff = off; go = 1;
      for (int i = 0; i < 5; i++) room[i] = 0;
      for (int l = 0; l < 2; l++) begin
         if (!go) break;
         if (!(l == 0 ? v0 : v1)) break;
         b = (l == 0) ? b0 : b1;
         lay = int'(b[4:2]);
         st = int'(b[1:0]);
         if (lay == 7 || (lay == 1 && st == 2)) begin
            eill = 1; eu++; noff = 0; go = 0;
            break;
         end
         at = (l == 0) ? off : 0;
         while (go && at < 3) begin
            k = LAY[lay][at];
            w = b[5 + 41*at +: 41];
            if (k != "X") begin
               c = cls_of(k);
               alt = -1;
               u = -1;
               if (k == "I" && w[40]) alt = 1;
               if (k == "M" && w[40]) alt = 0;
               if (room[c] < CAP_M[c]) u = c;
               else if (alt >= 0 && room[alt] < CAP_M[alt]) u = alt;
               if (u < 0) begin go = 0; break; end
               ev[BASE_M[u] + room[u]] = 1;
               if (k == "L") begin
                  ei[BASE_M[u] + room[u]] = b[5 + 82 +: 41];
                  elo = w;
               end else begin
                  ei[BASE_M[u] + room[u]] = w;
               end
               room[u]++;
            end
            at++;
            if (st != 0 && st == at) go = 0;
         end
         if (at == 3) begin eu++; noff = 0; end
         else begin noff = at; go = 0; end
      end
   endtask

   task automatic step(string tag, bit idle);
      bit [9:0] ev;
      bit [9:0][40:0] ei;
      bit [40:0] elo;
      int eu, noff;
      bit eill, v0, v1;
      @(negedge clk);
      v0 = !idle && q.size() > 0;
      v1 = !idle && q.size() > 1;
      in_vld = {v1, v0};
      in_bnd0 = v0 ? q[0] : '0;
      in_bnd1 = v1 ? q[1] : '0;
      #1;
      model(in_bnd0, in_bnd1, v0, v1, m_off, ev, ei, elo, eu, eill, noff);
      chk(tag, "unit_vld", 64'(unit_vld), 64'(ev));
      for (int u = 0; u < 10; u++)
         if (ev[u]) chk(tag, "unit_ins", 64'(unit_ins[u]), 64'(ei[u]));
      if (ev[9]) chk(tag, "ext_lo", 64'(ext_lo), 64'(elo));
      chk(tag, "bnd_used", 64'(bnd_used), 64'(eu));
      chk(tag, "bad_tmpl", 64'(bad_tmpl), 64'(eill));
      chk("R11", "issue_cap", 64'($countones(unit_vld) <= 6), 64'(1));
      @(posedge clk);
      m_off = noff;
      repeat (eu) void'(q.pop_front());
   endtask

   task automatic drain(string tag, int idle_mod);
      int n = 0;
      while (q.size() > 0 && n < 5000) begin
         step(tag, idle_mod > 0 && (n % idle_mod) == 1);
         n++;
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R10: quiet outputs while held in reset
      chk("R10", "unit_vld_rst", 64'(unit_vld), 64'(0));
      chk("R10", "bnd_used_rst", 64'(bnd_used), 64'(0));
      @(negedge clk);
      rst_n = 1'b1;

      // R10: leave a mid-bundle resume point, then reset restarts at slot 0
      q.push_back(mk(0, 1, 3'b000, 1));
      step("R10", 0);
      @(negedge clk);
      in_vld = 2'b00;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_off = 0;
      drain("R10", 0);

      // R1 / R2: every legal layout, no stops
      for (int l = 0; l < 7; l++) q.push_back(mk(l, 0, 3'b000, 10 + l));
      drain("R2", 0);
      for (int l = 6; l >= 0; l--) q.push_back(mk(l, 0, 3'b000, 20 + l));
      drain("R1", 0);

      // R5: stop markers at every position
      for (int s = 1; s < 4; s++) begin
         q.push_back(mk(0, s, 3'b000, 30 + s));
         q.push_back(mk(3, s, 3'b000, 40 + s));
      end
      drain("R5", 0);

      // R4: unit class exhaustion
      repeat (3) q.push_back(mk(5, 0, 3'b000, 50));
      repeat (3) q.push_back(mk(2, 0, 3'b000, 51));
      drain("R4", 0);

      // R3: ALU steering between INT and MEM
      repeat (3) q.push_back(mk(0, 0, 3'b110, 60));
      repeat (2) q.push_back(mk(2, 0, 3'b011, 61));
      repeat (2) q.push_back(mk(0, 0, 3'b001, 62));
      drain("R3", 0);

      // R6: extended-immediate pairs
      repeat (3) q.push_back(mk(1, 0, 3'b000, 70));
      q.push_back(mk(1, 3, 3'b000, 71));
      q.push_back(mk(1, 1, 3'b000, 72));
      drain("R6", 0);

      // R7: illegal templates
      q.push_back(mk(7, 0, 3'b000, 80));
      q.push_back(mk(0, 0, 3'b000, 81));
      q.push_back(mk(1, 2, 3'b000, 82));
      q.push_back(mk(7, 3, 3'b000, 83));
      q.push_back(mk(4, 0, 3'b000, 84));
      drain("R7", 0);

      // R9: idle gaps with a pending resume point
      q.push_back(mk(4, 1, 3'b000, 90));
      q.push_back(mk(5, 2, 3'b000, 91));
      q.push_back(mk(2, 2, 3'b000, 92));
      drain("R9", 2);

      // R8: long random stream
      for (int i = 0; i < 600; i++) begin
         bit [127:0] b;
         b = {$urandom(), $urandom(), $urandom(), $urandom()};
         q.push_back(b);
      end
      drain("R8", 0);
      for (int i = 0; i < 200; i++)
         q.push_back(mk(int'($urandom_range(0, 6)), int'($urandom_range(0, 3)),
                        3'($urandom()), i));
      drain("R8", 5);

      summary();
      $finish;
   end
endmodule